// File: doc/BRIEF.md
# Dual Latched Interval Timer

This block holds two 16-bit down-counters, each paired with a 16-bit latch, and gives access to both through a byte-wide register window. Software builds a 16-bit value one byte at a time: a write to a low-byte address only changes the latch, and a write to the timer's counter-high address completes the value, copies it into the counter and arms the timer. Both counters decrement once per clock without stopping.

Timer 1 can run one-shot or free-running, chosen by one bit of a mode register. In free-running mode the counter runs down from the latch value through zero and through 0xFFFF, then reloads from the latch, so each period is the latch value plus two clocks. Timer 2 is always one-shot. Each timer reports its zero crossing as a single-cycle pulse. Reads are combinational on the address, with no side effects.

Top module: `dual_interval_timer`

## Requirements
- R1: A write to address 0 or to address 2 replaces only latch-1 bits 7..0. Latch-1 bits 15..8 are unchanged, and the timer-1 counter keeps decrementing without a reload.
- R2: A write to address 1 stores the byte as latch-1 bits 15..8. On the same edge it loads the counter with {byte, latch-1 bits 7..0} and arms timer 1. The new counter value is readable in the cycle after that edge.
- R3: A write to address 3 stores the byte as latch-1 bits 15..8. It does not reload the counter, which keeps decrementing.
- R4: When mode bit 6 is set, timer 1 follows the sequence L, L-1, ..., 0, 0xFFFF, L. Its zero pulses are therefore L+2 cycles apart.
- R5: `t1Irq` is high for exactly the cycle in which the timer-1 counter is zero, provided the timer is armed or in free-running mode. In one-shot mode the pulse comes once per arming write. After it, the counter wraps to 0xFFFF and keeps decrementing without a reload.
- R6: The mode register is at address 6 and all 8 bits read back. Only bit 6 selects free-running mode. A change to that bit governs the next decrement after the write edge.
- R7: A write to address 4 replaces only latch-2 bits 7..0 and does not disturb the timer-2 counter. A write to address 5 loads counter 2 with {byte, latch-2 bits 7..0} and arms it. `t2Irq` pulses once, in the cycle counter 2 is zero, and counter 2 then wraps without a reload.
- R8: Reads are combinational on the address: 0/1 return counter-1 low/high, 2/3 return latch-1 low/high, 4/5 return counter-2 low/high, and 6 returns the mode register.
- R9: After reset, both latches and both counters are 0xFFFF, the mode register is 0, neither timer is armed and both pulses are low. Counters decrement from the first edge after reset is released.
- R10: Addresses 7 to 15 read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; counters step on every rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the byte on `wrData` |
| addr | input | 4 | Register address for writes and reads |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Read byte selected by `addr` |
| t1Irq | output | 1 | Timer-1 zero pulse |
| t2Irq | output | 1 | Timer-2 zero pulse |

## Verification
A write takes effect on the edge that samples it. A counter load is therefore visible on `rdData` at the next falling edge, and the zero pulse of a value L appears exactly L falling edges after that. In free-running mode, two falling edges after a pulse show 0xFFFF and then L. The bench drives every write for one cycle starting at a falling edge and samples combinational reads a fraction of a nanosecond later. It counts falling edges from each arming write, so every pulse and counter value is compared in the exact cycle the requirements place it. Sweeps over short latch values compute these expected distances arithmetically.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_T1_CNT_LO = 4'd0;
  localparam logic [ADDR_W-1:0] A_T1_CNT_HI = 4'd1;
  localparam logic [ADDR_W-1:0] A_T1_LAT_LO = 4'd2;
  localparam logic [ADDR_W-1:0] A_T1_LAT_HI = 4'd3;
  localparam logic [ADDR_W-1:0] A_T2_CNT_LO = 4'd4;
  localparam logic [ADDR_W-1:0] A_T2_CNT_HI = 4'd5;
  localparam logic [ADDR_W-1:0] A_MODE      = 4'd6;

  typedef struct packed {
    logic              t1LoWr;
    logic              t1CntHiWr;
    logic              t1LatHiWr;
    logic              t2LoWr;
    logic              t2CntHiWr;
    logic              modeWr;
    logic [BYTE_W-1:0] wrByte;
  } dit_strobe_t;
endpackage

// File: rtl/dit_timer.sv
module dit_timer
  import dit_pkg::*;
#(
  parameter bit HAS_RELOAD = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loLatWr,
  input  logic              hiLatWr,
  input  logic              hiCntWr,
  input  logic              contMode,
  input  logic [BYTE_W-1:0] wrByte,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  latch,
  output logic              irq
);
  logic armed;
  logic wrapNow;
  logic freeRun;

  assign freeRun = HAS_RELOAD && contMode;
  assign irq     = (cnt == '0) && (armed || freeRun);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latch   <= '1;
      cnt     <= '1;
      armed   <= 1'b0;
      wrapNow <= 1'b0;
    end else begin
      if (loLatWr) latch[BYTE_W-1:0] <= wrByte;
      if (hiLatWr || hiCntWr) latch[CNT_W-1:BYTE_W] <= wrByte;
      if (hiCntWr) begin
        cnt     <= {wrByte, latch[BYTE_W-1:0]};
        armed   <= 1'b1;
        wrapNow <= 1'b0;
      end else begin
        cnt     <= (freeRun && wrapNow) ? latch : cnt - CNT_W'(1);
        wrapNow <= (cnt == '0);
        if (irq) armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dit_ctrl.sv
module dit_ctrl
  import dit_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [CNT_W-1:0]  t1Cnt,
  input  logic [CNT_W-1:0]  t1Latch,
  input  logic [CNT_W-1:0]  t2Cnt,
  input  logic [BYTE_W-1:0] modeReg,
  output dit_strobe_t       strobes,
  output logic [BYTE_W-1:0] rdData
);
  always_comb begin
    strobes           = '0;
    strobes.wrByte    = wrData;
    strobes.t1LoWr    = wrEn && (addr == A_T1_CNT_LO || addr == A_T1_LAT_LO);
    strobes.t1CntHiWr = wrEn && (addr == A_T1_CNT_HI);
    strobes.t1LatHiWr = wrEn && (addr == A_T1_LAT_HI);
    strobes.t2LoWr    = wrEn && (addr == A_T2_CNT_LO);
    strobes.t2CntHiWr = wrEn && (addr == A_T2_CNT_HI);
    strobes.modeWr    = wrEn && (addr == A_MODE);
  end

  always_comb begin
    case (addr)
      A_T1_CNT_LO: rdData = t1Cnt[BYTE_W-1:0];
      A_T1_CNT_HI: rdData = t1Cnt[CNT_W-1:BYTE_W];
      A_T1_LAT_LO: rdData = t1Latch[BYTE_W-1:0];
      A_T1_LAT_HI: rdData = t1Latch[CNT_W-1:BYTE_W];
      A_T2_CNT_LO: rdData = t2Cnt[BYTE_W-1:0];
      A_T2_CNT_HI: rdData = t2Cnt[CNT_W-1:BYTE_W];
      A_MODE:      rdData = modeReg;
      default:     rdData = '0;
    endcase
  end
endmodule

// File: rtl/dit_datapath.sv
module dit_datapath
  import dit_pkg::*;
#(
  parameter int MODE_BIT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dit_strobe_t       strobes,
  output logic [CNT_W-1:0]  t1Cnt,
  output logic [CNT_W-1:0]  t1Latch,
  output logic [CNT_W-1:0]  t2Cnt,
  output logic [BYTE_W-1:0] modeReg,
  output logic              t1Irq,
  output logic              t2Irq
);
  localparam int N_TMR = 2;

  logic [N_TMR-1:0]            loWr, hiLatWr, hiCntWr, contSel, irqVec;
  logic [N_TMR-1:0][CNT_W-1:0] cntVec, latVec;

  always_ff @(posedge clk) begin
    if (!rstN) modeReg <= '0;
    else if (strobes.modeWr) modeReg <= strobes.wrByte;
  end

  assign loWr    = {strobes.t2LoWr, strobes.t1LoWr};
  assign hiLatWr = {1'b0, strobes.t1LatHiWr};
  assign hiCntWr = {strobes.t2CntHiWr, strobes.t1CntHiWr};
  assign contSel = {1'b0, modeReg[MODE_BIT]};

  for (genvar gi = 0; gi < N_TMR; gi++) begin : g_tmr
    dit_timer #(.HAS_RELOAD(gi == 0)) u_tmr (
      .clk     (clk),
      .rstN    (rstN),
      .loLatWr (loWr[gi]),
      .hiLatWr (hiLatWr[gi]),
      .hiCntWr (hiCntWr[gi]),
      .contMode(contSel[gi]),
      .wrByte  (strobes.wrByte),
      .cnt     (cntVec[gi]),
      .latch   (latVec[gi]),
      .irq     (irqVec[gi])
    );
  end

  assign t1Cnt   = cntVec[0];
  assign t1Latch = latVec[0];
  assign t2Cnt   = cntVec[1];
  assign t1Irq   = irqVec[0];
  assign t2Irq   = irqVec[1];
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int MODE_BIT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  output logic              t1Irq,
  output logic              t2Irq
);
  dit_strobe_t       strobes;
  logic [CNT_W-1:0]  t1Cnt, t1Latch, t2Cnt;
  logic [BYTE_W-1:0] modeReg;

  dit_ctrl u_ctrl (
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .t1Cnt  (t1Cnt),
    .t1Latch(t1Latch),
    .t2Cnt  (t2Cnt),
    .modeReg(modeReg),
    .strobes(strobes),
    .rdData (rdData)
  );

  dit_datapath #(.MODE_BIT(MODE_BIT)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .t1Cnt  (t1Cnt),
    .t1Latch(t1Latch),
    .t2Cnt  (t2Cnt),
    .modeReg(modeReg),
    .t1Irq  (t1Irq),
    .t2Irq  (t2Irq)
  );
endmodule

// File: rtl/dit_checker.sv
module dit_checker
  import dit_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [BYTE_W-1:0] wrData,
  input logic [CNT_W-1:0]  t1Cnt,
  input logic [CNT_W-1:0]  t1Latch,
  input logic [CNT_W-1:0]  t2Cnt,
  input logic [BYTE_W-1:0] modeReg,
  input logic              t1Irq,
  input logic              t2Irq
);
  // R1: low writes keep the counter counting and the latch high byte intact
  a_r1_low_no_reload: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (addr == A_T1_CNT_LO || addr == A_T1_LAT_LO) && !modeReg[6])
    |=> (t1Cnt == $past(t1Cnt) - 16'd1) &&
        (t1Latch[15:8] == $past(t1Latch[15:8])));

  // R2: counter-high write loads the full value
  a_r2_commit_load: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_T1_CNT_HI)
    |=> t1Cnt == {$past(wrData), $past(t1Latch[7:0])});

  // R3: latch-high write does not reload
  a_r3_latch_hi_only: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_T1_LAT_HI && !modeReg[6])
    |=> (t1Cnt == $past(t1Cnt) - 16'd1) && (t1Latch[15:8] == $past(wrData)));

  // R4: in free-running mode the wrap state is followed by a reload
  a_r4_reload: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[6] && t1Cnt == 16'hFFFF && $past(t1Cnt) == 16'h0000 &&
     $past(!(wrEn && addr == A_T1_CNT_HI)) && !(wrEn && addr == A_T1_CNT_HI))
    |=> t1Cnt == $past(t1Latch));

  // R5: timer-1 pulse only at zero
  a_r5_pulse_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    t1Irq |-> t1Cnt == 16'h0000);

  // R7: timer-2 pulse only at zero and never two in a row without re-arming
  a_r7_t2_zero: assert property (@(posedge clk) disable iff (!rstN)
    t2Irq |-> t2Cnt == 16'h0000);
  a_r7_t2_single: assert property (@(posedge clk) disable iff (!rstN)
    (t2Irq && !(wrEn && addr == A_T2_CNT_HI)) |=> !t2Irq);
endmodule

bind dual_interval_timer dit_checker u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .addr   (addr),
  .wrData (wrData),
  .t1Cnt  (t1Cnt),
  .t1Latch(t1Latch),
  .t2Cnt  (t2Cnt),
  .modeReg(modeReg),
  .t1Irq  (t1Irq),
  .t2Irq  (t2Irq)
);

// File: tb/tb_dual_interval_timer.sv
module tb_dual_interval_timer;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       t1Irq, t2Irq;

  int nRun = 0;
  int nFail = 0;

  dual_interval_timer dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .t1Irq(t1Irq), .t2Irq(t2Irq)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    addr = a;
    #0.1;
    v = int'(rdData);
  endtask

  task automatic waitIrq(input bit which, input int maxc, output int c);
    c = 0;
    while (!(which ? t2Irq : t1Irq) && c < maxc) begin
      @(negedge clk);
      c++;
    end
    if (!(which ? t2Irq : t1Irq)) c = -1;
  endtask

  task automatic countIrq(input bit which, input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (which ? t2Irq : t1Irq) hits++;
    end
  endtask

  initial begin
    #(8 * 150000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int v, c, h;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R9 reset state, before the first counting edge
    rd(0, v); chk("R9 cnt1 lo", v, 8'hFF);
    rd(1, v); chk("R9 cnt1 hi", v, 8'hFF);
    rd(2, v); chk("R9 lat1 lo", v, 8'hFF);
    rd(3, v); chk("R9 lat1 hi", v, 8'hFF);
    rd(4, v); chk("R9 cnt2 lo", v, 8'hFF);
    rd(6, v); chk("R9 mode", v, 0);
    chk("R9 pulses", {t1Irq, t2Irq}, 0);
    @(negedge clk);
    rd(0, v); chk("R9 first decrement", v, 8'hFE);

    // R5 one-shot sweep on timer 1
    for (int L = 0; L <= 20; L++) begin
      wr(0, 8'(L)); wr(1, 8'h00);
      waitIrq(0, L + 5, c); chk("R5 one-shot delay", c, L);
      @(negedge clk);
      rd(0, v); chk("R5 wrap lo", v, 8'hFF);
      rd(1, v); chk("R5 wrap hi", v, 8'hFF);
      countIrq(0, L + 4, h); chk("R5 no second pulse", h, 0);
    end

    // R2 full value load visible next cycle
    wr(0, 8'h34); wr(1, 8'h02);
    rd(0, v); chk("R2 load lo", v, 8'h34);
    rd(1, v); chk("R2 load hi", v, 8'h02);
    rd(3, v); chk("R2 latch hi", v, 8'h02);

    // R4 free-running sweep
    wr(6, 8'h40);
    for (int L = 0; L <= 12; L++) begin
      wr(0, 8'(L)); wr(1, 8'h00);
      waitIrq(0, L + 5, c); chk("R4 first pulse", c, L);
      @(negedge clk);
      rd(0, v); chk("R4 wrap lo", v, 8'hFF);
      rd(1, v); chk("R4 wrap hi", v, 8'hFF);
      @(negedge clk);
      rd(0, v); chk("R4 reload lo", v, L);
      rd(1, v); chk("R4 reload hi", v, 0);
      waitIrq(0, L + 5, c); chk("R4 period", c + 2, L + 2);
    end

    // R6 clearing bit 6 at the pulse stops the reload
    wr(0, 8'd4); wr(1, 8'h00);
    waitIrq(0, 10, c); chk("R6 pulse", c, 4);
    wr(6, 8'h00);
    @(negedge clk);
    rd(0, v); chk("R6 no reload lo", v, 8'hFE);
    rd(1, v); chk("R6 no reload hi", v, 8'hFF);
    countIrq(0, 20, h); chk("R6 no pulses", h, 0);

    // R6 other mode bits read back but do not select free-running
    wr(6, 8'hBF);
    rd(6, v); chk("R6 readback", v, 8'hBF);
    wr(0, 8'd3); wr(1, 8'h00);
    waitIrq(0, 10, c); chk("R6 one-shot delay", c, 3);
    @(negedge clk); @(negedge clk);
    rd(0, v); chk("R6 still one-shot", v, 8'hFE);
    wr(6, 8'h00);

    // R1 low writes do not disturb the count
    wr(0, 8'd30); wr(1, 8'h00);
    wr(0, 8'h55); wr(2, 8'h66);
    rd(2, v); chk("R1 latch lo", v, 8'h66);
    rd(3, v); chk("R1 latch hi kept", v, 8'h00);
    waitIrq(0, 40, c); chk("R1 pulse time kept", c, 28);

    // R3 latch-high write without reload
    wr(0, 8'd30); wr(1, 8'h00);
    wr(3, 8'h12);
    rd(3, v); chk("R3 latch hi", v, 8'h12);
    rd(1, v); chk("R3 counter hi kept", v, 8'h00);
    rd(0, v); chk("R3 counter lo", v, 29);
    waitIrq(0, 40, c); chk("R3 pulse time", c, 29);

    // R7 timer 2 sweep
    for (int L = 0; L <= 10; L++) begin
      wr(4, 8'(L)); wr(5, 8'h00);
      waitIrq(1, L + 5, c); chk("R7 one-shot delay", c, L);
      @(negedge clk);
      rd(4, v); chk("R7 wrap lo", v, 8'hFF);
      rd(5, v); chk("R7 wrap hi", v, 8'hFF);
      countIrq(1, L + 4, h); chk("R7 no second pulse", h, 0);
    end
    wr(4, 8'd20); wr(5, 8'h00);
    wr(4, 8'h03);
    waitIrq(1, 30, c); chk("R7 low write keeps count", c, 19);

    // R8 / R10 unmapped addresses
    rd(2, v);
    begin
      int lat0, lat1, md;
      lat0 = v;
      rd(3, lat1); rd(6, md);
      wr(9, 8'hAA); wr(15, 8'h55); wr(7, 8'h11);
      rd(9, v);  chk("R10 read 9", v, 0);
      rd(15, v); chk("R10 read 15", v, 0);
      rd(2, v);  chk("R10 latch lo kept", v, lat0);
      rd(3, v);  chk("R10 latch hi kept", v, lat1);
      rd(6, v);  chk("R8 mode kept", v, md);
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule